// File: doc/BRIEF.md
# Fourth-Order Decimating Filter with Settled-Only Output

This block turns the one-bit stream from a sigma-delta modulator into signed 24-bit conversion words. Each modulator bit counts as +1 or -1. Four cascaded running sums feed four cascaded differences, which form a fourth-order box (sinc4) filter. The differences are evaluated once per decimation period, and a period is 64 times the programmed 10-bit rate word. The rate word therefore sets the output word rate directly. Because a fourth-order box filter spans four periods, every word the block releases has seen a full window of fresh samples.

Two operating styles are offered. In streaming mode the block drops the first three results after any restart and then releases one word per period. In settled-only mode every conversion starts from cleared filter state, and one word is released after four periods. That gives a quarter of the streaming rate, and every word depends only on its own samples. A restart strobe resets the filter, for example when the analog front end switches channel. Changing the rate word or the mode has the same effect. The filter value is shifted right by a parameter and clipped to the 24-bit signed range.

Top module: `sinc4_decim`

## Requirements
- R1: One decimation period is 64×F accepted samples, where F is the rate word. A rate word of 0 acts as 1.
- R2: In streaming mode (zero_lat=0), no word appears for the first three periods after a restart. After that, one word appears at the end of each period. Its value is the sum of h[k]·x[m−k], where h is the fourfold self-convolution of a length-64F box, m is the latest sample, and samples from before the restart count as 0. A bit value of 1 maps to +1 and a bit value of 0 maps to −1.
- R3: In settled-only mode (zero_lat=1), one word appears every 4×64F samples. Each word uses only the samples of its own conversion, so at most one word mixes the two levels of an input step.
- R4: A cycle with restart high clears all filter state and discards any sample offered in that cycle. No word is released in the following cycle.
- R5: A change of rate word or of mode with restart low causes the same restart as the strobe.
- R6: The output word is the filter value shifted arithmetically right by OUT_SHIFT (default 6), clipped to the range −8388608 to +8388607.
- R7: dout_valid is high for a single cycle per word. dout keeps its value while dout_valid is low.
- R8: A sample is taken only in a cycle with mod_en high. Cycles with mod_en low change neither the filter state nor the period count.
- R9: After reset, dout_valid is 0 and dout is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_bit | input | 1 | Modulator output bit |
| mod_en | input | 1 | Qualifies mod_bit as a new sample |
| fs_sel | input | 10 | Rate word; the decimation ratio is 64×fs_sel |
| zero_lat | input | 1 | 1 selects settled-only conversions |
| restart | input | 1 | Single-cycle strobe that restarts the filter (channel change) |
| dout | output | 24 | Signed conversion word |
| dout_valid | output | 1 | Single-cycle strobe marking a new dout |

## Verification
The assertions check structure on every cycle:
- dout_valid is a single-cycle pulse, and dout stays stable between pulses.
- No word follows a restart in the next cycle.
- The sample count stays below the active ratio.
- The running sums are zero after a restart and stay frozen in idle cycles.
- A settled-only word always closes its conversion.

Only the bench scenarios can show that the words carry the right values. The bench compares each word against a direct convolution reference, for constant, pseudo-random, sparse and step inputs. It also checks how many words come out after a strobe, a rate change and a mode change. Finally, it checks clipping at both rails and the handling of a zero rate word.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;
   // Running-sum width: four stages of log2(max ratio) growth plus a sign bit.
   function automatic int acc_bits(int mult, int fsw);
      return 4 * $clog2(mult * ((1 << fsw) - 1)) + 1;
   endfunction
endpackage

// File: rtl/sinc4_integ.sv
module sinc4_integ #(
   parameter int ACC_W = 65
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    fresh,
   input  logic                    en,
   input  logic                    bit_i,
   output logic signed [ACC_W-1:0] acc_o
);
   logic signed [ACC_W-1:0] st  [0:3];
   logic signed [ACC_W-1:0] nxt [0:3];
   logic signed [ACC_W-1:0] x;

   // Map the modulator bit to +1 / -1, then chain the four running sums.
   // When fresh is set, the old state counts as zero.
   always_comb begin
      x = bit_i ? ACC_W'(1) : '1;
      for (int i = 0; i < 4; i++) begin
         nxt[i] = (fresh ? '0 : st[i]) + ((i == 0) ? x : nxt[(i == 0) ? 0 : i-1]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) st[i] <= '0;
      end else if (clr) begin
         for (int i = 0; i < 4; i++) st[i] <= '0;
      end else if (en) begin
         for (int i = 0; i < 4; i++) st[i] <= nxt[i];
      end else if (fresh) begin
         for (int i = 0; i < 4; i++) st[i] <= '0;
      end
   end

   assign acc_o = st[3];

   a_r4_integ_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_o == '0));
   a_r8_integ_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr && !fresh) |=> (acc_o == $past(acc_o)));
endmodule

// File: rtl/sinc4_comb.sv
module sinc4_comb #(
   parameter int ACC_W = 65
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    dec,
   input  logic                    wipe,
   input  logic signed [ACC_W-1:0] din,
   output logic signed [ACC_W-1:0] y
);
   logic signed [ACC_W-1:0] dly [0:3];
   logic signed [ACC_W-1:0] s   [0:4];

   // Four cascaded differences against the sample taken one period earlier.
   always_comb begin
      s[0] = din;
      for (int i = 0; i < 4; i++) s[i+1] = s[i] - dly[i];
   end
   assign y = s[4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) dly[i] <= '0;
      end else if (clr) begin
         for (int i = 0; i < 4; i++) dly[i] <= '0;
      end else if (dec) begin
         for (int i = 0; i < 4; i++) dly[i] <= wipe ? '0 : s[i];
      end
   end
endmodule

// File: rtl/sinc4_outfmt.sv
module sinc4_outfmt #(
   parameter int ACC_W = 65,
   parameter int OUT_W = 24,
   parameter int SHIFT = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic signed [ACC_W-1:0] din,
   output logic [OUT_W-1:0]        dout,
   output logic                    valid
);
   localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] MINV = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   logic signed [ACC_W-1:0] shv;
   logic [OUT_W-1:0]        fmt;

   assign shv = din >>> SHIFT;

   generate
      if (ACC_W - SHIFT > OUT_W) begin : g_clip
         always_comb begin
            if (shv > MAXV)      fmt = MAXV[OUT_W-1:0];
            else if (shv < MINV) fmt = MINV[OUT_W-1:0];
            else                 fmt = shv[OUT_W-1:0];
         end
      end else begin : g_fit
         logic unused_hi;
         assign unused_hi = ^shv[ACC_W-1:OUT_W];
         assign fmt = shv[OUT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= load;
         if (load) dout <= fmt;
      end
   end
endmodule

// File: rtl/sinc4_decim.sv
module sinc4_decim #(
   parameter int FS_W      = 10,
   parameter int OSR_MULT  = 64,
   parameter int OUT_W     = 24,
   parameter int OUT_SHIFT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_bit,
   input  logic              mod_en,
   input  logic [FS_W-1:0]   fs_sel,
   input  logic              zero_lat,
   input  logic              restart,
   output logic [OUT_W-1:0]  dout,
   output logic              dout_valid
);
   localparam int ACC_W = sinc4_pkg::acc_bits(OSR_MULT, FS_W);
   localparam int CNT_W = $clog2(OSR_MULT * (2 ** FS_W));

   generate
      if (OUT_SHIFT >= ACC_W) begin : g_bad_shift
         $error("OUT_SHIFT must be below the running-sum width");
      end
      if (ACC_W < OUT_W) begin : g_bad_width
         $error("running-sum width must cover the output width");
      end
      if (OSR_MULT < 2) begin : g_bad_mult
         $error("OSR_MULT must be at least 2");
      end
   endgenerate

   logic [FS_W-1:0]  fs_q;
   logic             zl_q;
   logic             cfg_chg, rs, accept;
   logic [FS_W-1:0]  fs_eff;
   logic [CNT_W-1:0] ratio, cnt;
   logic             dec_q, emit, fresh;
   logic [1:0]       ph;
   logic signed [ACC_W-1:0] i4, cy;

   assign fs_eff  = (fs_sel == '0) ? FS_W'(1) : fs_sel;
   assign ratio   = CNT_W'(fs_eff) * CNT_W'(OSR_MULT);
   assign cfg_chg = (fs_sel != fs_q) || (zero_lat != zl_q);
   assign rs      = restart || cfg_chg;
   assign accept  = mod_en && !rs;
   assign emit    = dec_q && !rs && (ph == 2'd3);
   assign fresh   = emit && zl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q  <= '0;
         zl_q  <= 1'b0;
         cnt   <= '0;
         dec_q <= 1'b0;
         ph    <= '0;
      end else begin
         fs_q <= fs_sel;
         zl_q <= zero_lat;
         if (rs) begin
            cnt   <= '0;
            dec_q <= 1'b0;
            ph    <= '0;
         end else begin
            dec_q <= accept && (cnt == ratio - CNT_W'(1));
            if (accept) cnt <= (cnt == ratio - CNT_W'(1)) ? '0 : cnt + CNT_W'(1);
            if (dec_q) ph <= (ph == 2'd3) ? (zl_q ? 2'd0 : 2'd3) : ph + 2'd1;
         end
      end
   end

   sinc4_integ #(.ACC_W(ACC_W)) u_integ (
      .clk(clk), .rst_n(rst_n), .clr(rs), .fresh(fresh),
      .en(accept), .bit_i(mod_bit), .acc_o(i4)
   );

   sinc4_comb #(.ACC_W(ACC_W)) u_comb (
      .clk(clk), .rst_n(rst_n), .clr(rs), .dec(dec_q && !rs),
      .wipe(fresh), .din(i4), .y(cy)
   );

   sinc4_outfmt #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(OUT_SHIFT)) u_fmt (
      .clk(clk), .rst_n(rst_n), .load(emit), .din(cy),
      .dout(dout), .valid(dout_valid)
   );

   a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid |=> !dout_valid);
   a_r7_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_valid |-> $stable(dout));
   a_r4_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rs |=> !dout_valid);
   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_chg |-> (cnt < ratio));
   a_r3_conv_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_valid && zl_q) |-> (ph == 2'd0));
endmodule

// File: tb/sinc4_decim_bench.sv
module sinc4_decim_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SHIFT      = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mod_bit = 1'b0;
   logic        mod_en = 1'b0;
   logic [9:0]  fs_sel = 10'd1;
   logic        zero_lat = 1'b0;
   logic        restart = 1'b0;
   logic [23:0] dout;
   logic        dout_valid;

   int checks = 0;
   int errors = 0;
   int ngot = 0;
   longint got [0:63];
   int xs [0:2047];
   longint h [0:1023];
   longint tmp [0:1023];
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   sinc4_decim u_sinc4_decim (
      .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .mod_en(mod_en),
      .fs_sel(fs_sel), .zero_lat(zero_lat), .restart(restart),
      .dout(dout), .dout_valid(dout_valid)
   );

   always @(negedge clk) begin
      if (rst_n && dout_valid && ngot < 64) begin
         got[ngot] = longint'($signed(dout));
         ngot = ngot + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint clip(input longint v);
      longint s = v >>> SHIFT;
      if (s > 64'sd8388607)  return 64'sd8388607;
      if (s < -64'sd8388608) return -64'sd8388608;
      return s;
   endfunction

   task automatic build_h(input int r);
      for (int i = 0; i < 1024; i++) h[i] = (i < r) ? 1 : 0;
      for (int p = 0; p < 3; p++) begin
         for (int i = 0; i < 1024; i++) begin
            tmp[i] = 0;
            for (int j = 0; j < r; j++) if (i - j >= 0) tmp[i] += h[i-j];
         end
         for (int i = 0; i < 1024; i++) h[i] = tmp[i];
      end
   endtask

   task automatic do_restart(input int fs, input bit zl, input bit strobe);
      @(negedge clk);
      fs_sel = 10'(fs); zero_lat = zl; restart = strobe; mod_en = 1'b0;
      @(negedge clk);
      restart = 1'b0;
      @(negedge clk);
   endtask

   // kind: 0 ones, 1 zeros, 2 pseudo-random, 3 unaligned step, 4 sparse ones
   task automatic run_seg(input int fs, input bit zl, input int kind, input int n,
                          input int gap, input string req);
      int r = 64 * ((fs == 0) ? 1 : fs);
      int nexp;
      ngot = 0;
      for (int m = 1; m <= n; m++) begin
         int b;
         case (kind)
            0: b = 1;
            1: b = 0;
            2: begin lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; b = lfsr[0]; end
            3: b = (m <= 5 * r + r / 3) ? 1 : 0;
            default: b = (m % 4 == 0) ? 1 : 0;
         endcase
         xs[m] = b ? 1 : -1;
         @(negedge clk);
         mod_bit = b[0]; mod_en = 1'b1;
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            mod_en = 1'b0; mod_bit = ~mod_bit;
         end
      end
      @(negedge clk);
      mod_en = 1'b0;
      repeat (6) @(negedge clk);
      nexp = zl ? n / (4 * r) : ((n / r >= 4) ? n / r - 3 : 0);
      chk(ngot == nexp, {req, " word count"}, ngot, nexp);
      build_h(r);
      for (int j = 0; j < nexp && j < ngot; j++) begin
         int m = zl ? 4 * r * (j + 1) : r * (j + 4);
         int base = zl ? m - 4 * r + 1 : 1;
         longint y = 0;
         for (int k = 0; k <= 4 * r - 4; k++)
            if (m - k >= base) y += h[k] * xs[m-k];
         chk(got[j] == clip(y), {req, " word value"}, got[j], clip(y));
      end
   endtask

   task automatic t_reset;
      chk(dout_valid == 1'b0, "R9 valid after reset", dout_valid, 0);
      chk(dout == 24'd0, "R9 dout after reset", dout, 0);
   endtask

   task automatic t_stream;
      do_restart(1, 0, 1);
      run_seg(1, 0, 0, 6 * 64, 0, "R2 ones");
      do_restart(1, 0, 1);
      run_seg(1, 0, 2, 8 * 64, 0, "R2 random");
      do_restart(1, 0, 1);
      run_seg(1, 0, 4, 7 * 64, 0, "R2 sparse");
      do_restart(1, 0, 1);
      run_seg(1, 0, 3, 12 * 64, 0, "R2 step");
   endtask

   task automatic t_settled;
      do_restart(1, 1, 1);
      run_seg(1, 1, 3, 12 * 64, 0, "R3 step");
      do_restart(2, 1, 1);
      run_seg(2, 1, 2, 8 * 128, 0, "R3 random");
   endtask

   task automatic t_channel;
      do_restart(1, 0, 1);
      run_seg(1, 0, 2, 5 * 64 + 32, 0, "R4 before strobe");
      do_restart(1, 0, 1);
      run_seg(1, 0, 1, 6 * 64, 0, "R4 after strobe");
   endtask

   task automatic t_cfg_change;
      do_restart(1, 0, 1);
      run_seg(1, 0, 0, 6 * 64 + 10, 0, "R5 before rate change");
      do_restart(2, 0, 0);
      run_seg(2, 0, 2, 6 * 128, 0, "R5 after rate change");
      do_restart(2, 1, 0);
      run_seg(2, 1, 4, 4 * 128, 0, "R5 after mode change");
   endtask

   task automatic t_zero_rate;
      do_restart(0, 0, 1);
      run_seg(0, 0, 2, 6 * 64, 0, "R1 rate word zero");
   endtask

   task automatic t_clip;
      do_restart(3, 0, 1);
      run_seg(3, 0, 0, 5 * 192, 0, "R6 clip high");
      if (ngot > 0) chk(got[0] == 8388607, "R6 top rail", got[0], 8388607);
      do_restart(3, 0, 1);
      run_seg(3, 0, 1, 5 * 192, 0, "R6 clip low");
      if (ngot > 0) chk(got[0] == -8388608, "R6 bottom rail", got[0], -8388608);
   endtask

   task automatic t_enable_gaps;
      do_restart(1, 0, 1);
      run_seg(1, 0, 2, 6 * 64, 2, "R8 enable gaps");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_stream();
      t_settled();
      t_channel();
      t_cfg_change();
      t_zero_rate();
      t_clip();
      t_enable_gaps();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule